// File: doc/BRIEF.md
# Bit-Serial Mesh Node with Forward-First Routing

This block is one node of a two-dimensional mesh whose links carry a single bit per clock. It is built for the lowest possible per-node delay. A bit that arrives on a link is sent on at once to the output that continues in the same dimension. The node checks the destination address while those bits are already on their way. Routing is dimension-ordered: a packet first travels along dimension 0 and makes at most one turn into dimension 1.

A packet entering on the dimension-0 input carries two address flits: the dimension-0 destination, then the dimension-1 destination. As the first flit streams through, the node compares it bit by bit with its own dimension-0 coordinate. On a full match, the copy of that flit already sent straight ahead is closed off as a dead address flit. The rest of the packet then turns onto the dimension-1 output, and the dimension-0 flit is stripped from it. The dimension-1 flit is handled the same way. It is forwarded first and compared afterwards. On a match it becomes a dead flit on the dimension-1 output, and the payload goes to the local port.

The dimension-1 output and the local port can each be wanted by both inputs. Each of them is held by the stream that claimed it first, until that stream ends. A stream that cannot get its output is dropped, because the node stores nothing.

Top module: `mesh_postman_node`

## Requirements
- R1: Every link carries one bit per cycle as a valid wire, a data wire and a dead wire. A packet is an unbroken run of valid cycles and is followed by at least one idle cycle. Address flits are COORD_W (default 4) bits wide and are sent most significant bit first. A packet on the dimension-0 input sends the dimension-0 destination, then the dimension-1 destination, then one or more payload bits. A packet on the dimension-1 input sends the dimension-1 destination, then its payload.
- R2: Every bit the node forwards leaves on its output exactly one cycle after it arrives. The first address flit of a dimension-0 packet always leaves on the dimension-0 output, whatever its value.
- R3: When the dimension-0 destination differs from the node's dimension-0 coordinate, in any bit position, the whole packet leaves unchanged on the dimension-0 output with the dead wire low. Nothing appears on the other outputs.
- R4: When the dimension-0 destination matches, the dimension-0 output carries only the COORD_W bits of that flit. The dead wire is high on the last of those bits and low on the others, and the output goes idle in the next cycle.
- R5: After a dimension-0 match with a dimension-1 mismatch, the dimension-1 flit and the payload leave on the dimension-1 output with the dead wire low. Nothing reaches the local port.
- R6: After matches in both dimensions, the dimension-1 output carries only the dimension-1 flit, with the dead wire high on its last bit. The payload leaves on the local port and nothing else reaches that port.
- R7: A packet on the dimension-1 input leaves whole on the dimension-1 output when its destination differs from the node's dimension-1 coordinate. When the destination matches, its flit becomes a dead flit on that output (dead wire high on the last bit) and its payload goes to the local port.
- R8: A dead flit that arrives, meaning an input run whose last bit has the dead wire high, leaves on the straight output with its dead marking kept. It never produces any traffic on the turn output or the local port.
- R9: The dimension-1 output and the local port are each granted only to a stream whose run starts while the output is free. The holder keeps the output until its run ends. A run that starts while the output is held is dropped in full, even if the output becomes free before that run ends.
- R10: When a dimension-1-input stream and a dimension-0-input stream start wanting the same free output in the same cycle, the dimension-1-input stream gets it.
- R11: While reset is asserted, every output valid, data and dead wire is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| myX | input | COORD_W | The node's own dimension-0 coordinate |
| myY | input | COORD_W | The node's own dimension-1 coordinate |
| xInValid | input | 1 | Dimension-0 input link: bit present |
| xInBit | input | 1 | Dimension-0 input link: data bit |
| xInDead | input | 1 | Dimension-0 input link: dead-flit mark on the last bit |
| yInValid | input | 1 | Dimension-1 input link: bit present |
| yInBit | input | 1 | Dimension-1 input link: data bit |
| yInDead | input | 1 | Dimension-1 input link: dead-flit mark on the last bit |
| xOutValid | output | 1 | Dimension-0 output link: bit present |
| xOutBit | output | 1 | Dimension-0 output link: data bit |
| xOutDead | output | 1 | Dimension-0 output link: dead-flit mark |
| yOutValid | output | 1 | Dimension-1 output link: bit present |
| yOutBit | output | 1 | Dimension-1 output link: data bit |
| yOutDead | output | 1 | Dimension-1 output link: dead-flit mark |
| locValid | output | 1 | Local delivery: payload bit present |
| locBit | output | 1 | Local delivery: payload bit |

## Verification
The hardest situations to reach are the collisions on the two shared outputs. These are a turning stream that starts while a straight stream holds the dimension-1 output and outlives it, and two streams whose claims begin in the very same cycle. Random traffic almost never lines packets up that exactly. The bench therefore forks the two input drivers with offsets counted in clock cycles, so that the second claim lands inside, or exactly on, the first one. Most of the coverage comes from seeded random packets sent one at a time, with random coordinates biased towards matches. Directed cases add address mismatches in only the first or only the last bit, and incoming dead flits on both inputs.

// File: rtl/postman_pkg.sv
`timescale 1ns/1ps
package postman_pkg;

  // Where the bit seen this cycle on one input goes, and whether it closes a dead flit.
  typedef struct packed {
    logic toX;
    logic toY;
    logic toLoc;
    logic dead;
  } routeStrb_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HDR0,
    PH_HDR1,
    PH_BODY
  } phase_t;

  typedef enum logic [1:0] {
    DIR_X,
    DIR_Y,
    DIR_LOC
  } dir_t;

  typedef enum logic [1:0] {
    OWN_NONE,
    OWN_A,
    OWN_B
  } owner_t;

endpackage

// File: rtl/postman_ctrl.sv
`timescale 1ns/1ps
module postman_ctrl #(
  parameter int COORD_W = 4,
  parameter bit IS_DIM0 = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [COORD_W-1:0]     myX,
  input  logic [COORD_W-1:0]     myY,
  input  logic                   inValid,
  input  logic                   inBit,
  input  logic                   inDead,
  output postman_pkg::routeStrb_t strb
);
  import postman_pkg::*;

  localparam int IDX_W = (COORD_W > 1) ? $clog2(COORD_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COORD_W - 1);

  phase_t          phaseQ, phaseCur;
  logic [IDX_W-1:0] idxQ, idxCur, msbIdx;
  logic            accQ, accCur;
  dir_t            dirQ;
  logic            refBit, bitEq, lastAddr;

  // A packet starts in the first address flit this input expects.
  always_comb begin
    if (phaseQ == PH_IDLE) begin
      phaseCur = IS_DIM0 ? PH_HDR0 : PH_HDR1;
      idxCur   = '0;
      accCur   = 1'b1;
    end else begin
      phaseCur = phaseQ;
      idxCur   = idxQ;
      accCur   = accQ;
    end
  end

  assign msbIdx   = LAST_IDX - idxCur;
  assign refBit   = (phaseCur == PH_HDR0) ? myX[msbIdx] : myY[msbIdx];
  assign bitEq    = accCur & (inBit == refBit);
  assign lastAddr = (idxCur == LAST_IDX);

  // Route of the current bit: address bits go straight, the verdict only marks the tail.
  always_comb begin
    strb = '0;
    if (inValid) begin
      case (phaseCur)
        PH_HDR0: begin
          strb.toX  = 1'b1;
          strb.dead = inDead | (lastAddr & bitEq);
        end
        PH_HDR1: begin
          strb.toY  = 1'b1;
          strb.dead = inDead | (lastAddr & bitEq);
        end
        PH_BODY: begin
          strb.toX   = (dirQ == DIR_X);
          strb.toY   = (dirQ == DIR_Y);
          strb.toLoc = (dirQ == DIR_LOC);
          strb.dead  = inDead;
        end
        default: strb = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      idxQ   <= '0;
      accQ   <= 1'b1;
      dirQ   <= DIR_X;
    end else if (!inValid) begin
      phaseQ <= PH_IDLE;
      idxQ   <= '0;
      accQ   <= 1'b1;
    end else if (phaseCur == PH_HDR0 || phaseCur == PH_HDR1) begin
      if (lastAddr) begin
        idxQ <= '0;
        accQ <= 1'b1;
        if (phaseCur == PH_HDR0) begin
          if (bitEq) begin
            phaseQ <= PH_HDR1;
          end else begin
            phaseQ <= PH_BODY;
            dirQ   <= DIR_X;
          end
        end else begin
          phaseQ <= PH_BODY;
          dirQ   <= bitEq ? DIR_LOC : DIR_Y;
        end
      end else begin
        phaseQ <= phaseCur;
        idxQ   <= idxCur + 1'b1;
        accQ   <= bitEq;
      end
    end else begin
      phaseQ <= phaseCur;
    end
  end

  // R2
  first_bit_straight_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !$past(inValid)) |-> (IS_DIM0 ? strb.toX : strb.toY));

endmodule

// File: rtl/postman_portsel.sv
`timescale 1ns/1ps
module postman_portsel (
  input  logic clk,
  input  logic rstN,
  input  logic reqA,
  input  logic reqB,
  output logic grantA,
  output logic grantB
);
  import postman_pkg::*;

  owner_t ownerQ, ownerNext;
  logic   prevA, prevB, riseA, riseB;

  assign riseA = reqA & ~prevA;
  assign riseB = reqB & ~prevB;

  // Holder keeps the output; otherwise only a freshly started run may claim it, A first.
  always_comb begin
    if (ownerQ == OWN_A && reqA)      ownerNext = OWN_A;
    else if (ownerQ == OWN_B && reqB) ownerNext = OWN_B;
    else if (riseA)                   ownerNext = OWN_A;
    else if (riseB)                   ownerNext = OWN_B;
    else                              ownerNext = OWN_NONE;
  end

  assign grantA = (ownerNext == OWN_A);
  assign grantB = (ownerNext == OWN_B);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerQ <= OWN_NONE;
      prevA  <= 1'b0;
      prevB  <= 1'b0;
    end else begin
      ownerQ <= ownerNext;
      prevA  <= reqA;
      prevB  <= reqB;
    end
  end

  // R9
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantA |-> reqA) and (grantB |-> reqB));

  // R9
  holder_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantB |=> (!reqB || grantB)) and (grantA |=> (!reqA || grantA)));

  // R9
  no_late_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((reqB && !grantB) |=> (!reqB || !grantB)) and ((reqA && !grantA) |=> (!reqA || !grantA)));

  // R10
  tie_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (riseA && riseB) |-> grantA);

endmodule

// File: rtl/postman_datapath.sv
`timescale 1ns/1ps
module postman_datapath #(
  parameter int NUM_SHARED = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inXBit,
  input  logic                    inYBit,
  input  postman_pkg::routeStrb_t sx,
  input  postman_pkg::routeStrb_t sy,
  output logic                    xOutValid,
  output logic                    xOutBit,
  output logic                    xOutDead,
  output logic                    yOutValid,
  output logic                    yOutBit,
  output logic                    yOutDead,
  output logic                    locValid,
  output logic                    locBit
);
  // Shared output 0 is the dimension-1 link, 1 is the local port; requester A is the dimension-1 input.
  logic [NUM_SHARED-1:0] reqA, reqB, gA, gB;

  assign reqA[0] = sy.toY;
  assign reqB[0] = sx.toY;
  assign reqA[1] = sy.toLoc;
  assign reqB[1] = sx.toLoc;

  for (genvar g = 0; g < NUM_SHARED; g++) begin : g_shared
    postman_portsel i_sel (
      .clk    (clk),
      .rstN   (rstN),
      .reqA   (reqA[g]),
      .reqB   (reqB[g]),
      .grantA (gA[g]),
      .grantB (gB[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xOutValid <= 1'b0;
      xOutBit   <= 1'b0;
      xOutDead  <= 1'b0;
      yOutValid <= 1'b0;
      yOutBit   <= 1'b0;
      yOutDead  <= 1'b0;
      locValid  <= 1'b0;
      locBit    <= 1'b0;
    end else begin
      xOutValid <= sx.toX;
      xOutBit   <= sx.toX & inXBit;
      xOutDead  <= sx.toX & sx.dead;
      yOutValid <= gA[0] | gB[0];
      yOutBit   <= gA[0] ? inYBit : (gB[0] & inXBit);
      yOutDead  <= (gA[0] & sy.dead) | (gB[0] & sx.dead);
      locValid  <= gA[1] | gB[1];
      locBit    <= gA[1] ? inYBit : (gB[1] & inXBit);
    end
  end

  // R4
  dead_ends_frag_chk: assert property (@(posedge clk) disable iff (!rstN)
    xOutDead |=> !xOutValid);

endmodule

// File: rtl/mesh_postman_node.sv
`timescale 1ns/1ps
module mesh_postman_node #(
  parameter int COORD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COORD_W-1:0] myX,
  input  logic [COORD_W-1:0] myY,
  input  logic               xInValid,
  input  logic               xInBit,
  input  logic               xInDead,
  input  logic               yInValid,
  input  logic               yInBit,
  input  logic               yInDead,
  output logic               xOutValid,
  output logic               xOutBit,
  output logic               xOutDead,
  output logic               yOutValid,
  output logic               yOutBit,
  output logic               yOutDead,
  output logic               locValid,
  output logic               locBit
);
  import postman_pkg::*;

  routeStrb_t sx, sy;

  postman_ctrl #(.COORD_W(COORD_W), .IS_DIM0(1'b1)) i_ctrlX (
    .clk(clk), .rstN(rstN), .myX(myX), .myY(myY),
    .inValid(xInValid), .inBit(xInBit), .inDead(xInDead), .strb(sx)
  );

  postman_ctrl #(.COORD_W(COORD_W), .IS_DIM0(1'b0)) i_ctrlY (
    .clk(clk), .rstN(rstN), .myX(myX), .myY(myY),
    .inValid(yInValid), .inBit(yInBit), .inDead(yInDead), .strb(sy)
  );

  postman_datapath #(.NUM_SHARED(2)) i_dp (
    .clk(clk), .rstN(rstN), .inXBit(xInBit), .inYBit(yInBit),
    .sx(sx), .sy(sy),
    .xOutValid(xOutValid), .xOutBit(xOutBit), .xOutDead(xOutDead),
    .yOutValid(yOutValid), .yOutBit(yOutBit), .yOutDead(yOutDead),
    .locValid(locValid), .locBit(locBit)
  );

  // R2
  fwd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    xOutValid |-> $past(xInValid));

endmodule

// File: tb/test_mesh_postman_node.sv
`timescale 1ns/1ps
module test_mesh_postman_node;
  localparam int CW = 4;

  typedef struct packed {
    logic [31:0] cyc;
    logic        b;
    logic        d;
  } ent_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic [CW-1:0] myX, myY;
  logic xInValid, xInBit, xInDead, yInValid, yInBit, yInDead;
  logic xOutValid, xOutBit, xOutDead, yOutValid, yOutBit, yOutDead, locValid, locBit;

  mesh_postman_node #(.COORD_W(CW)) i_mesh_postman_node (
    .clk(clk), .rstN(rstN), .myX(myX), .myY(myY),
    .xInValid(xInValid), .xInBit(xInBit), .xInDead(xInDead),
    .yInValid(yInValid), .yInBit(yInBit), .yInDead(yInDead),
    .xOutValid(xOutValid), .xOutBit(xOutBit), .xOutDead(xOutDead),
    .yOutValid(yOutValid), .yOutBit(yOutBit), .yOutDead(yOutDead),
    .locValid(locValid), .locBit(locBit)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  ent_t gotX[$], gotY[$], gotL[$];
  ent_t expX[$], expY[$], expL[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (xOutValid) gotX.push_back({32'(cyc), xOutBit, xOutDead});
      if (yOutValid) gotY.push_back({32'(cyc), yOutBit, yOutDead});
      if (locValid)  gotL.push_back({32'(cyc), locBit, 1'b0});
    end
  end

  function automatic logic [79:0] mkStream(input logic [CW-1:0] dx, input logic [CW-1:0] dy,
                                           input bit withX, input logic [63:0] pay,
                                           input int plen, output int len);
    logic [79:0] s = '0;
    int p = 0;
    if (withX) for (int k = 0; k < CW; k++) begin s[p] = dx[CW-1-k]; p++; end
    for (int k = 0; k < CW; k++) begin s[p] = dy[CW-1-k]; p++; end
    for (int k = 0; k < plen; k++) begin s[p] = pay[k]; p++; end
    len = p;
    return s;
  endfunction

  // Expected output bits of one packet, from the routing rules R3..R8.
  task automatic expectPkt(input bit fromX, input logic [79:0] s, input int len, input int t0,
                           input logic deadIn, input bit dropY, input bit dropL);
    int base = 0;
    logic [CW-1:0] a;
    if (fromX) begin
      for (int k = 0; k < CW; k++) a[CW-1-k] = s[k];
      if (a != myX) begin
        for (int i = 0; i < len; i++) expX.push_back({32'(t0+i+1), s[i], deadIn && (i == len-1)});
        return;
      end
      for (int i = 0; i < CW; i++) expX.push_back({32'(t0+i+1), s[i], (i == CW-1)});
      base = CW;
    end
    if (len <= base) return;
    for (int k = 0; k < CW; k++) a[CW-1-k] = s[base+k];
    if (a != myY) begin
      if (!dropY) for (int i = base; i < len; i++)
        expY.push_back({32'(t0+i+1), s[i], deadIn && (i == len-1)});
    end else begin
      if (!dropY) for (int i = base; i < base+CW; i++)
        expY.push_back({32'(t0+i+1), s[i], (i == base+CW-1)});
      if (!dropL) for (int i = base+CW; i < len; i++)
        expL.push_back({32'(t0+i+1), s[i], 1'b0});
    end
  endtask

  task automatic cmpQ(input string tag, input string port, input ent_t got[$], input ent_t exp[$]);
    checks++;
    if (got.size() != exp.size()) begin
      errors++;
      $display("FAIL %s %s: %0d bits seen, expected %0d", tag, port, got.size(), exp.size());
      return;
    end
    for (int i = 0; i < got.size(); i++) begin
      if (got[i] != exp[i]) begin
        errors++;
        $display("FAIL %s %s bit %0d: got cyc=%0d b=%0b d=%0b expected cyc=%0d b=%0b d=%0b",
                 tag, port, i, got[i].cyc, got[i].b, got[i].d, exp[i].cyc, exp[i].b, exp[i].d);
        return;
      end
    end
  endtask

  task automatic settleAndCompare(input string tag);
    repeat (4) @(posedge clk);
    @(negedge clk);
    cmpQ(tag, "xOut", gotX, expX);
    cmpQ(tag, "yOut", gotY, expY);
    cmpQ(tag, "local", gotL, expL);
    gotX.delete(); gotY.delete(); gotL.delete();
    expX.delete(); expY.delete(); expL.delete();
  endtask

  task automatic sendX(input logic [79:0] s, input int len, input logic deadLast, output int t0);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      if (i == 0) t0 = cyc;
      xInValid = 1'b1; xInBit = s[i]; xInDead = deadLast && (i == len-1);
    end
    @(posedge clk); #1;
    xInValid = 1'b0; xInBit = 1'b0; xInDead = 1'b0;
  endtask

  task automatic sendY(input logic [79:0] s, input int len, input logic deadLast, output int t0);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      if (i == 0) t0 = cyc;
      yInValid = 1'b1; yInBit = s[i]; yInDead = deadLast && (i == len-1);
    end
    @(posedge clk); #1;
    yInValid = 1'b0; yInBit = 1'b0; yInDead = 1'b0;
  endtask

  task automatic runPkt(input string tag, input bit fromX, input logic [CW-1:0] dx,
                        input logic [CW-1:0] dy, input logic [63:0] pay, input int plen,
                        input logic deadLast, input int useLen);
    logic [79:0] s;
    int len, t0;
    s = mkStream(dx, dy, fromX, pay, plen, len);
    if (useLen > 0) len = useLen;
    if (fromX) sendX(s, len, deadLast, t0);
    else       sendY(s, len, deadLast, t0);
    expectPkt(fromX, s, len, t0, deadLast, 1'b0, 1'b0);
    settleAndCompare(tag);
  endtask

  // Watchdog: an expired run counts as a failed check.
  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, got running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [79:0] sA, sB;
    int lenA, lenB, tA, tB;
    logic [CW-1:0] dx, dy;
    logic [63:0] pay;
    int plen;
    bit fromX;
    string tag;

    void'($urandom(32'd20240611));
    myX = 4'h6; myY = 4'hA;
    rstN = 1'b0;
    xInValid = 0; xInBit = 0; xInDead = 0;
    yInValid = 0; yInBit = 0; yInDead = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: outputs quiet during reset
    checks++;
    if ({xOutValid, xOutBit, xOutDead, yOutValid, yOutBit, yOutDead, locValid, locBit} != 8'h00) begin
      errors++;
      $display("FAIL R11 reset outputs: got %b expected 00000000",
               {xOutValid, xOutBit, xOutDead, yOutValid, yOutBit, yOutDead, locValid, locBit});
    end
    @(posedge clk); #1;
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    // R1: mismatch in the most significant (first sent) address bit only
    runPkt("R1", 1'b1, myX ^ 4'b1000, myY, 64'h5A, 7, 1'b0, 0);
    // R2: mismatch in the last address bit only; every bit still one cycle late
    runPkt("R2", 1'b1, myX ^ 4'b0001, myY, 64'h3C, 6, 1'b0, 0);
    // R3: full mismatch
    runPkt("R3", 1'b1, ~myX, 4'h3, 64'hF0F, 12, 1'b0, 0);
    // R4, R5: turn into dimension 1
    runPkt("R5", 1'b1, myX, myY ^ 4'b0100, 64'h9, 5, 1'b0, 0);
    // R4, R6: eject with a single payload bit
    runPkt("R6", 1'b1, myX, myY, 64'h1, 1, 1'b0, 0);
    runPkt("R4", 1'b1, myX, myY, 64'hB6, 9, 1'b0, 0);
    // R7: dimension-1 input, mismatch and match
    runPkt("R7", 1'b0, 4'h0, myY ^ 4'b0010, 64'h6, 4, 1'b0, 0);
    runPkt("R7", 1'b0, 4'h0, myY, 64'hD3, 8, 1'b0, 0);
    // R8: incoming dead flits
    runPkt("R8", 1'b1, myX, 4'h0, 64'h0, 0, 1'b1, CW);
    runPkt("R8", 1'b1, myX ^ 4'b0110, 4'h0, 64'h0, 0, 1'b1, CW);
    runPkt("R8", 1'b0, 4'h0, myY, 64'h0, 0, 1'b1, 0);
    runPkt("R8", 1'b0, 4'h0, myY ^ 4'b1000, 64'h0, 0, 1'b1, 0);

    // R9: turning stream starts while the dimension-1 output is held and outlives the holder
    sA = mkStream(4'h0, myY ^ 4'b0001, 1'b0, 64'hA5, 8, lenA);
    sB = mkStream(myX, myY ^ 4'b1000, 1'b1, 64'hFACE1, 20, lenB);
    fork
      sendY(sA, lenA, 1'b0, tA);
      begin @(posedge clk); sendX(sB, lenB, 1'b0, tB); end
    join
    expectPkt(1'b0, sA, lenA, tA, 1'b0, 1'b0, 1'b0);
    expectPkt(1'b1, sB, lenB, tB, 1'b0, 1'b1, 1'b0);
    settleAndCompare("R9");

    // R9: local port held by the dimension-1 input; ejecting dimension-0 payload is dropped
    sA = mkStream(4'h0, myY, 1'b0, 64'h3355, 20, lenA);
    sB = mkStream(myX, myY, 1'b1, 64'hC7, 10, lenB);
    fork
      sendY(sA, lenA, 1'b0, tA);
      begin @(posedge clk); sendX(sB, lenB, 1'b0, tB); end
    join
    expectPkt(1'b0, sA, lenA, tA, 1'b0, 1'b0, 1'b0);
    expectPkt(1'b1, sB, lenB, tB, 1'b0, 1'b0, 1'b1);
    settleAndCompare("R9");

    // R10: both streams claim the dimension-1 output in the same cycle
    sA = mkStream(4'h0, myY ^ 4'b0011, 1'b0, 64'h2, 2, lenA);
    sB = mkStream(myX, myY ^ 4'b1100, 1'b1, 64'h7E1, 12, lenB);
    fork
      sendX(sB, lenB, 1'b0, tB);
      begin repeat (CW) @(posedge clk); sendY(sA, lenA, 1'b0, tA); end
    join
    expectPkt(1'b0, sA, lenA, tA, 1'b0, 1'b0, 1'b0);
    expectPkt(1'b1, sB, lenB, tB, 1'b0, 1'b1, 1'b0);
    settleAndCompare("R10");

    // Seeded random single packets, biased towards address matches
    for (int n = 0; n < 40; n++) begin
      fromX = 1'($urandom % 2);
      dx = ($urandom % 2) ? myX : 4'($urandom);
      dy = ($urandom % 2) ? myY : 4'($urandom);
      pay = {$urandom, $urandom};
      plen = 1 + int'($urandom % 16);
      if (!fromX)         tag = "R7";
      else if (dx != myX) tag = "R3";
      else if (dy != myY) tag = "R5";
      else                tag = "R6";
      runPkt(tag, fromX, dx, dy, pay, plen, 1'b0, 0);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule